// File: doc/BRIEF.md
# Masked Packed Half-Precision Subtract Unit

This block subtracts, lane by lane, the 16-bit IEEE half-precision elements of a second operand vector from those of a first operand vector held in a 512-bit register. A length select activates 8, 16 or 32 lanes. A per-lane write mask decides which lanes take the new difference. Lanes left unwritten are either zeroed or keep the previous destination contents. Everything above the active length is cleared. The second operand may come from memory with its element 0 replicated to all lanes. A per-operation rounding override is honoured only for full-length register-form operations.

The unit is a single registered stage. The result register and a set of sticky exception flags load on each cycle where `op_valid` is high. The flags collect invalid, denormal-operand, overflow, underflow and inexact conditions from the written lanes of every accepted operation. Only a reset clears them.

Top module: `hsub_vec_unit`

## Requirements
- R1: A synchronous active-high reset clears `res` to zero and `flags` to zero on the next clock edge.
- R2: A written lane holds the half-precision difference a_j − b_j, correctly rounded in the selected mode, one clock after `op_valid` is sampled high.
- R3: `vlen_sel` 0 makes lanes 0..7 active (128 bits), 1 makes lanes 0..15 active (256 bits), and 2 or 3 makes all 32 lanes active (512 bits); result bits from the active length up to bit 511 are zero.
- R4: An active lane j is written with the difference when `mask_en` is low, or when `wmask[j]` is 1.
- R5: An active lane that is not written becomes 0x0000 when `zero_mode` is 1, and takes lane j of `old_dst` when `zero_mode` is 0.
- R6: When both `b_is_mem` and `bcast` are 1, every lane subtracts `op_b[15:0]`. In every other case, lane j uses `op_b[16j+15:16j]`; a register operand is never broadcast.
- R7: Rounding encoding: 00 nearest-even, 01 toward −∞, 10 toward +∞, 11 toward zero. `static_rm` is used when the length is 512 bits, `b_is_mem` is 0 and `bcast` is 1. Otherwise `ctl_rm` is used.
- R8: A NaN input (exponent 31, mantissa nonzero), or infinities whose difference is undefined, yields 0x7E00. Invalid is raised for a signalling NaN input (mantissa bit 9 clear) or for the undefined infinity difference.
- R9: A rounded magnitude of 2^16 or more overflows. The result is infinity under nearest-even, toward zero gives magnitude 0x7BFF, and the directed modes give infinity only in their own direction and 0x7BFF otherwise. Overflow and inexact are raised.
- R10: A zero difference of two zeros whose effective signs agree keeps that sign. Any other exact zero is −0 (0x8000) under toward −∞ and +0 in all other modes.
- R11: Flag bit order is [0] invalid, [1] denormal operand, [2] overflow, [3] underflow, [4] inexact. Inexact is raised when the rounded result differs from the exact difference. Denormal is raised when an operand is subnormal and neither operand is a NaN. Underflow stays 0, because a tiny difference of two half-precision values is always exact.
- R12: `flags` is the OR of its previous value and the flags of the active, written lanes of each accepted operation. Masked or inactive lanes contribute nothing, and no bit falls without reset.
- R13: While `op_valid` is low, `res` and `flags` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accept an operation this cycle |
| vlen_sel | input | 2 | Active vector length select |
| op_a | input | 512 | Minuend lanes |
| op_b | input | 512 | Subtrahend lanes |
| old_dst | input | 512 | Previous destination contents, used for merging |
| wmask | input | 32 | Per-lane write mask |
| mask_en | input | 1 | Write mask in use |
| zero_mode | input | 1 | 1 zeroes unwritten lanes, 0 merges |
| bcast | input | 1 | Broadcast / override-enable bit |
| b_is_mem | input | 1 | Subtrahend comes from memory |
| static_rm | input | 2 | Per-operation rounding override |
| ctl_rm | input | 2 | Control-register rounding mode |
| res | output | 512 | Registered result vector |
| flags | output | 5 | Sticky exception flags |

## Verification
On every cycle, the bound checker watches the register-level behaviour. It checks that reset clears the outputs, that idle cycles hold them, that sticky flags never drop, and that an operation with every lane masked leaves the flags alone. It also checks that lane 0 obeys the zeroing and merging rules and that bits above 128 or 256 are cleared at the shorter lengths. The arithmetic itself can only be shown by the bench's scenarios, which compare against an exact real-valued model: rounding in all four modes, the overflow saturation direction, the signs of zero results, NaN and infinity handling, broadcast selection and the choice of rounding source.

// File: rtl/hsub_pkg.sv
package hsub_pkg;

    localparam int LANE_W   = 16;
    localparam int VL_MAX   = 512;
    localparam int VL_MIN   = 128;
    localparam int NLANES   = VL_MAX / LANE_W;
    localparam int NL_MIN   = VL_MIN / LANE_W;
    localparam int WIDE_W   = 42;   // exact fixed-point span of any FP16 sum
    localparam int MANT_W   = 10;
    localparam int EXP_W    = 5;
    localparam int FLAG_W   = 5;

    localparam logic [15:0] QNAN_DEFAULT = 16'h7E00;
    localparam logic [14:0] MAX_FINITE   = 15'h7BFF;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
        logic denorm;
        logic invalid;
    } xflags_t;

    typedef struct packed {
        xflags_t     fl;
        logic [15:0] val;
    } sub_res_t;

    function automatic logic [WIDE_W-1:0] to_fixed(input logic [EXP_W-1:0] e,
                                                   input logic [MANT_W-1:0] f);
        logic [WIDE_W-1:0] sig;
        logic [EXP_W-1:0]  sh;
        sig = WIDE_W'({e != '0, f});
        sh  = (e == '0) ? '0 : e - 5'd1;
        return sig << sh;
    endfunction

    function automatic sub_res_t fp16_sub(input logic [15:0] a,
                                          input logic [15:0] b,
                                          input rmode_e rm);
        sub_res_t          r;
        logic              sa, sb, rs, rb, st, inc, to_inf;
        logic [EXP_W-1:0]  ea, eb;
        logic [MANT_W-1:0] fa, fb;
        logic              a_nan, b_nan, a_snan, b_snan, a_inf, b_inf;
        logic [WIDE_W-1:0] ma, mb, mag, low_mask;
        logic [5:0]        p, sh, ex;
        logic [11:0]       kept;

        sa = a[15];
        sb = ~b[15];            // subtraction is addition of the negated operand
        ea = a[14:10];
        eb = b[14:10];
        fa = a[9:0];
        fb = b[9:0];
        a_nan  = (ea == 5'h1F) && (fa != '0);
        b_nan  = (eb == 5'h1F) && (fb != '0);
        a_snan = a_nan && !fa[9];
        b_snan = b_nan && !fb[9];
        a_inf  = (ea == 5'h1F) && (fa == '0);
        b_inf  = (eb == 5'h1F) && (fb == '0);
        r      = '0;

        if (a_nan || b_nan) begin
            r.val        = QNAN_DEFAULT;
            r.fl.invalid = a_snan | b_snan;
        end else begin
            r.fl.denorm = ((ea == '0) && (fa != '0)) || ((eb == '0) && (fb != '0));
            if (a_inf && b_inf) begin
                if (sa != sb) begin
                    r.val        = QNAN_DEFAULT;
                    r.fl.invalid = 1'b1;
                end else begin
                    r.val = {sa, 5'h1F, 10'h0};
                end
            end else if (a_inf) begin
                r.val = a;
            end else if (b_inf) begin
                r.val = {sb, 5'h1F, 10'h0};
            end else begin
                ma = to_fixed(ea, fa);
                mb = to_fixed(eb, fb);
                if (sa == sb) begin
                    mag = ma + mb;
                    rs  = sa;
                end else if (ma >= mb) begin
                    mag = ma - mb;
                    rs  = sa;
                end else begin
                    mag = mb - ma;
                    rs  = sb;
                end
                if (mag == '0) begin
                    r.val = (sa == sb) ? {sa, 15'h0} : {(rm == RM_DOWN), 15'h0};
                end else begin
                    p = '0;
                    for (int i = 0; i < WIDE_W; i++) begin
                        if (mag[i]) p = 6'(i);
                    end
                    if (p < 6'd10) begin
                        r.val = {rs, 5'h0, mag[9:0]};
                    end else begin
                        sh       = p - 6'd10;
                        kept     = 12'(mag >> sh);
                        rb       = (sh == '0) ? 1'b0 : mag[sh - 6'd1];
                        low_mask = (sh <= 6'd1) ? '0
                                 : ((WIDE_W'(1) << (sh - 6'd1)) - WIDE_W'(1));
                        st       = |(mag & low_mask);
                        ex       = p - 6'd9;
                        unique case (rm)
                            RM_NEAR: inc = rb & (st | kept[0]);
                            RM_DOWN: inc = (rb | st) & rs;
                            RM_UP:   inc = (rb | st) & ~rs;
                            default: inc = 1'b0;
                        endcase
                        kept = kept + 12'(inc);
                        if (kept[11]) begin
                            kept = kept >> 1;
                            ex   = ex + 6'd1;
                        end
                        r.fl.inexact = rb | st;
                        if (ex >= 6'd31) begin
                            to_inf = (rm == RM_NEAR) || (rm == RM_DOWN && rs)
                                   || (rm == RM_UP && !rs);
                            r.val         = to_inf ? {rs, 5'h1F, 10'h0} : {rs, MAX_FINITE};
                            r.fl.overflow = 1'b1;
                            r.fl.inexact  = 1'b1;
                        end else begin
                            r.val = {rs, ex[4:0], kept[9:0]};
                        end
                    end
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/hsub_ctl.sv
module hsub_ctl
    import hsub_pkg::*;
#(
    parameter int NL = NLANES
) (
    input  logic [1:0]    vlen_sel,
    input  logic          bcast,
    input  logic          b_is_mem,
    input  logic [1:0]    static_rm,
    input  logic [1:0]    ctl_rm,
    input  logic          mask_en,
    input  logic [NL-1:0] wmask,
    output logic [NL-1:0] lane_act,
    output logic [NL-1:0] lane_wr,
    output rmode_e        eff_rm,
    output logic          b_splat
);
    localparam int CNT_W = $clog2(NL + 1);

    logic             full_len;
    logic [CNT_W-1:0] n_active;

    assign full_len = vlen_sel[1];

    always_comb begin
        unique case (vlen_sel)
            2'd0:    n_active = CNT_W'(NL_MIN);
            2'd1:    n_active = CNT_W'(2 * NL_MIN);
            default: n_active = CNT_W'(NL);
        endcase
    end

    for (genvar j = 0; j < NL; j++) begin : g_sel
        assign lane_act[j] = (CNT_W'(j) < n_active);
        assign lane_wr[j]  = !mask_en || wmask[j];
    end

    assign eff_rm  = (full_len && !b_is_mem && bcast) ? rmode_e'(static_rm)
                                                       : rmode_e'(ctl_rm);
    assign b_splat = b_is_mem && bcast;
endmodule

// File: rtl/hsub_lane.sv
module hsub_lane
    import hsub_pkg::*;
(
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic [LANE_W-1:0] old,
    input  rmode_e            rm,
    input  logic              active,
    input  logic              wr,
    input  logic              zero_mode,
    output logic [LANE_W-1:0] out,
    output xflags_t           lflags
);
    sub_res_t diff;

    always_comb begin
        diff = fp16_sub(a, b, rm);
        if (!active) begin
            out = '0;
        end else if (wr) begin
            out = diff.val;
        end else if (zero_mode) begin
            out = '0;
        end else begin
            out = old;
        end
        lflags = (active && wr) ? diff.fl : '0;
    end
endmodule

// File: rtl/hsub_vec_unit.sv
module hsub_vec_unit
    import hsub_pkg::*;
#(
    parameter int MAX_VL = VL_MAX
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     op_valid,
    input  logic [1:0]               vlen_sel,
    input  logic [MAX_VL-1:0]        op_a,
    input  logic [MAX_VL-1:0]        op_b,
    input  logic [MAX_VL-1:0]        old_dst,
    input  logic [MAX_VL/LANE_W-1:0] wmask,
    input  logic                     mask_en,
    input  logic                     zero_mode,
    input  logic                     bcast,
    input  logic                     b_is_mem,
    input  logic [1:0]               static_rm,
    input  logic [1:0]               ctl_rm,
    output logic [MAX_VL-1:0]        res,
    output logic [FLAG_W-1:0]        flags
);
    localparam int NL = MAX_VL / LANE_W;

    logic [NL-1:0]     lane_act;
    logic [NL-1:0]     lane_wr;
    rmode_e            eff_rm;
    logic              b_splat;
    logic [MAX_VL-1:0] next_res;
    xflags_t           lane_fl [NL];
    xflags_t           op_fl;
    xflags_t           sticky_q;

    hsub_ctl #(.NL(NL)) u_ctl (
        .vlen_sel  (vlen_sel),
        .bcast     (bcast),
        .b_is_mem  (b_is_mem),
        .static_rm (static_rm),
        .ctl_rm    (ctl_rm),
        .mask_en   (mask_en),
        .wmask     (wmask),
        .lane_act  (lane_act),
        .lane_wr   (lane_wr),
        .eff_rm    (eff_rm),
        .b_splat   (b_splat)
    );

    for (genvar j = 0; j < NL; j++) begin : g_lane
        logic [LANE_W-1:0] b_src;
        assign b_src = b_splat ? op_b[LANE_W-1:0] : op_b[j*LANE_W +: LANE_W];

        hsub_lane u_lane (
            .a         (op_a[j*LANE_W +: LANE_W]),
            .b         (b_src),
            .old       (old_dst[j*LANE_W +: LANE_W]),
            .rm        (eff_rm),
            .active    (lane_act[j]),
            .wr        (lane_wr[j]),
            .zero_mode (zero_mode),
            .out       (next_res[j*LANE_W +: LANE_W]),
            .lflags    (lane_fl[j])
        );
    end

    always_comb begin
        op_fl = '0;
        for (int j = 0; j < NL; j++) begin
            op_fl = op_fl | lane_fl[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res      <= '0;
            sticky_q <= '0;
        end else if (op_valid) begin
            res      <= next_res;
            sticky_q <= sticky_q | op_fl;
        end
    end

    assign flags = sticky_q;
endmodule

// File: rtl/hsub_vec_chk.sv
module hsub_vec_chk
    import hsub_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 op_valid,
    input logic [1:0]           vlen_sel,
    input logic [VL_MAX-1:0]    old_dst,
    input logic [NLANES-1:0]    wmask,
    input logic                 mask_en,
    input logic                 zero_mode,
    input logic [VL_MAX-1:0]    res,
    input logic [FLAG_W-1:0]    flags
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (res == '0) && (flags == '0));

    // R13
    a_r13_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(op_valid)) |-> ($stable(res) && $stable(flags)));

    // R12
    a_r12_sticky_mono: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flags & $past(flags)) == $past(flags)));

    // R12
    a_r12_masked_no_flags: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_valid && mask_en && (wmask == '0)))
        |-> (flags == $past(flags)));

    // R3
    a_r3_upper_zero_128: assert property (@(posedge clk) disable iff (rst)
        $past(op_valid && vlen_sel == 2'd0) |-> (res[VL_MAX-1:128] == '0));

    // R3
    a_r3_upper_zero_256: assert property (@(posedge clk) disable iff (rst)
        $past(op_valid && vlen_sel == 2'd1) |-> (res[VL_MAX-1:256] == '0));

    // R5
    a_r5_zero_lane0: assert property (@(posedge clk) disable iff (rst)
        $past(op_valid && mask_en && !wmask[0] && zero_mode) |-> (res[15:0] == 16'h0));

    // R5
    a_r5_merge_lane0: assert property (@(posedge clk) disable iff (rst)
        $past(op_valid && mask_en && !wmask[0] && !zero_mode)
        |-> (res[15:0] == $past(old_dst[15:0])));
endmodule

bind hsub_vec_unit hsub_vec_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .vlen_sel  (vlen_sel),
    .old_dst   (old_dst),
    .wmask     (wmask),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .res       (res),
    .flags     (flags)
);

// File: tb/hsub_vec_unit_bench.sv
`timescale 1ns/1ps
module hsub_vec_unit_bench;
    localparam int NL = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         op_valid;
    logic [1:0]   vlen_sel;
    logic [511:0] op_a, op_b, old_dst;
    logic [31:0]  wmask;
    logic         mask_en, zero_mode, bcast, b_is_mem;
    logic [1:0]   static_rm, ctl_rm;
    logic [511:0] res;
    logic [4:0]   flags;

    int           n_checks = 0;
    int           n_errors = 0;
    logic [511:0] exp_res;
    logic [4:0]   exp_flags;

    always #4 clk = ~clk;

    hsub_vec_unit u_hsub_vec_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .vlen_sel(vlen_sel),
        .op_a(op_a), .op_b(op_b), .old_dst(old_dst), .wmask(wmask),
        .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
        .b_is_mem(b_is_mem), .static_rm(static_rm), .ctl_rm(ctl_rm),
        .res(res), .flags(flags)
    );

    // ---------------- reference model (exact real arithmetic) ----------------
    function automatic real p2(int k);
        real r = 1.0;
        if (k >= 0) repeat (k) r = r * 2.0;
        else repeat (-k) r = r / 2.0;
        return r;
    endfunction

    function automatic real h2r(logic [15:0] h);
        int  e = int'(h[14:10]);
        int  f = int'(h[9:0]);
        real v = (e == 0) ? f * p2(-24) : (1024 + f) * p2(e - 25);
        return h[15] ? -v : v;
    endfunction

    function automatic bit is_nan(logic [15:0] h);
        return (h[14:10] == 5'h1F) && (h[9:0] != 0);
    endfunction

    function automatic bit is_inf(logic [15:0] h);
        return (h[14:10] == 5'h1F) && (h[9:0] == 0);
    endfunction

    function automatic bit is_sub(logic [15:0] h);
        return (h[14:10] == 0) && (h[9:0] != 0);
    endfunction

    // returns {flags[4:0], value[15:0]}; flags [0]inv [1]den [2]ovf [3]unf [4]inx
    function automatic logic [20:0] ref_sub(logic [15:0] a, logic [15:0] b, logic [1:0] rm);
        logic [4:0]  fl = 5'b0;
        logic [15:0] v;
        real d, m, q, n, fl_n, fr, r;
        int  nr, ex;
        bit  s, up;
        if (is_nan(a) || is_nan(b)) begin
            fl[0] = (is_nan(a) && !a[9]) || (is_nan(b) && !b[9]);
            return {fl, 16'h7E00};
        end
        fl[1] = is_sub(a) || is_sub(b);
        if (is_inf(a) && is_inf(b)) begin
            if (a[15] == b[15]) begin fl[0] = 1'b1; return {fl, 16'h7E00}; end
            return {fl, a};
        end
        if (is_inf(a)) return {fl, a};
        if (is_inf(b)) return {fl, ~b[15], b[14:0]};
        d = h2r(a) - h2r(b);
        if (d == 0.0) begin
            if (a[14:0] == 0 && b[14:0] == 0 && a[15] != b[15]) return {fl, a[15], 15'h0};
            return {fl, (rm == 2'b01), 15'h0};
        end
        s = (d < 0.0);
        m = s ? -d : d;
        q = p2(-24);
        while (m >= 2048.0 * q) q = q * 2.0;
        n    = m / q;
        fl_n = $floor(n);
        fr   = n - fl_n;
        nr   = $rtoi(fl_n);
        case (rm)
            2'b00:   up = (fr > 0.5) || (fr == 0.5 && (nr % 2) == 1);
            2'b01:   up = (fr > 0.0) && s;
            2'b10:   up = (fr > 0.0) && !s;
            default: up = 1'b0;
        endcase
        fl[4] = (fr != 0.0);
        r = (nr + (up ? 1 : 0)) * q;
        if (r >= 65536.0) begin
            fl[2] = 1'b1;
            fl[4] = 1'b1;
            if (rm == 2'b00 || (rm == 2'b01 && s) || (rm == 2'b10 && !s))
                return {fl, s, 15'h7C00};
            return {fl, s, 15'h7BFF};
        end
        if (r < p2(-14)) begin
            v = {s, 5'h0, 10'($rtoi(r / p2(-24)))};
        end else begin
            ex = 1;
            q  = p2(-24);
            while (r >= 2048.0 * q) begin q = q * 2.0; ex++; end
            v = {s, 5'(ex), 10'($rtoi(r / q) - 1024)};
        end
        return {fl, v};
    endfunction

    task automatic model_op();
        int          nact;
        logic [1:0]  rm;
        logic [15:0] bl;
        logic [20:0] rr;
        nact = (vlen_sel == 0) ? 8 : (vlen_sel == 1) ? 16 : 32;
        rm   = (vlen_sel >= 2 && !b_is_mem && bcast) ? static_rm : ctl_rm;
        exp_res = '0;
        for (int j = 0; j < NL; j++) begin
            if (j < nact) begin
                bl = (b_is_mem && bcast) ? op_b[15:0] : op_b[j*16 +: 16];
                if (!mask_en || wmask[j]) begin
                    rr = ref_sub(op_a[j*16 +: 16], bl, rm);
                    exp_res[j*16 +: 16] = rr[15:0];
                    exp_flags = exp_flags | rr[20:16];
                end else if (!zero_mode) begin
                    exp_res[j*16 +: 16] = old_dst[j*16 +: 16];
                end
            end
        end
    endtask

    task automatic check_out(string tag);
        n_checks++;
        if (res !== exp_res) begin
            n_errors++;
            $display("FAIL %s res: actual %h expected %h", tag, res, exp_res);
        end
        n_checks++;
        if (flags !== exp_flags) begin
            n_errors++;
            $display("FAIL %s flags: actual %b expected %b", tag, flags, exp_flags);
        end
    endtask

    task automatic defaults();
        vlen_sel = 2'd2; mask_en = 0; zero_mode = 0; bcast = 0; b_is_mem = 0;
        static_rm = 0; ctl_rm = 0; wmask = '0; op_a = '0; op_b = '0; old_dst = '0;
    endtask

    task automatic run_op(string tag);
        op_valid = 1'b1;
        model_op();
        @(posedge clk);
        #2;
        op_valid = 1'b0;
        check_out(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; op_valid = 1'b0;
        @(posedge clk); #2;
        rst = 1'b0;
        exp_res = '0; exp_flags = '0;
        check_out("R1");
    endtask

    function automatic logic [511:0] fill(logic [15:0] h);
        return {32{h}};
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        #(8 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        defaults();
        op_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        do_reset();

        // R2: plain full-width subtraction
        op_a = fill(16'h4200); op_b = fill(16'h3C00);
        op_a[31:16] = 16'h3C00; op_b[31:16] = 16'h4000;
        run_op("R2");
        // R2: random data, all rounding modes via control field
        for (int m = 0; m < 4; m++) begin
            op_a = rnd512(); op_b = rnd512(); ctl_rm = 2'(m);
            run_op("R2");
        end
        // R11: tie case 2048 - 0.5 in each mode, inexact flag
        do_reset();
        op_a = fill(16'h6800); op_b = fill(16'h3800);
        for (int m = 0; m < 4; m++) begin ctl_rm = 2'(m); run_op("R11"); end
        // R11: denormal operand
        do_reset();
        op_a = fill(16'h0003); op_b = fill(16'h0001);
        run_op("R11");

        // R3: shorter lengths clear upper bits
        do_reset();
        op_a = rnd512(); op_b = rnd512(); old_dst = rnd512();
        vlen_sel = 2'd0; run_op("R3");
        vlen_sel = 2'd1; run_op("R3");
        vlen_sel = 2'd3; run_op("R3");

        // R4 / R5: masking, merge and zero
        vlen_sel = 2'd2; mask_en = 1; wmask = 32'hA5C3_0F01; old_dst = rnd512();
        zero_mode = 0; run_op("R5");
        zero_mode = 1; run_op("R5");
        mask_en = 0; run_op("R4");

        // R12: all lanes masked add no flags even with invalid data
        do_reset();
        mask_en = 1; wmask = '0; zero_mode = 0;
        op_a = fill(16'h7C01); op_b = fill(16'h3C00);
        run_op("R12");
        // R12: only the one written lane raises invalid; flags then stay sticky
        wmask = 32'h0000_0100; run_op("R12");
        op_a = fill(16'h3C00); mask_en = 0; run_op("R12");

        // R6: memory broadcast versus register form
        do_reset();
        op_a = rnd512(); op_b = rnd512(); op_b[15:0] = 16'h3555;
        b_is_mem = 1; bcast = 1; run_op("R6");
        b_is_mem = 0; bcast = 1; run_op("R6");
        b_is_mem = 1; bcast = 0; run_op("R6");

        // R7: override only at full length with register operand
        do_reset();
        op_a = fill(16'h6800); op_b = fill(16'h3800);
        b_is_mem = 0; bcast = 1; static_rm = 2'b11; ctl_rm = 2'b10;
        vlen_sel = 2'd2; run_op("R7");
        vlen_sel = 2'd1; run_op("R7");
        vlen_sel = 2'd2; b_is_mem = 1; run_op("R7");
        b_is_mem = 0; bcast = 0; run_op("R7");

        // R8: NaN propagation and inf - inf
        do_reset(); defaults();
        op_a = fill(16'h7E12); op_b = fill(16'h3C00); run_op("R8");
        op_a = fill(16'h7C00); op_b = fill(16'h7C00); run_op("R8");
        do_reset();
        op_a = fill(16'h7C00); op_b = fill(16'hFC00); run_op("R8");
        op_a = fill(16'h3C00); op_b = fill(16'h7D00); run_op("R8");

        // R9: overflow direction per mode, both signs
        for (int m = 0; m < 4; m++) begin
            do_reset();
            ctl_rm = 2'(m);
            op_a = fill(16'h7BFF); op_b = fill(16'hFBFF);
            op_a[15:0] = 16'hFBFF; op_b[15:0] = 16'h7BFF;
            run_op("R9");
        end

        // R10: signs of exact zero
        do_reset();
        op_a = fill(16'h3C00); op_b = fill(16'h3C00);
        op_a[15:0] = 16'h0000; op_b[15:0] = 16'h0000;
        op_a[31:16] = 16'h8000; op_b[31:16] = 16'h0000;
        op_a[47:32] = 16'h0000; op_b[47:32] = 16'h8000;
        for (int m = 0; m < 4; m++) begin ctl_rm = 2'(m); run_op("R10"); end

        // R13: idle cycles hold outputs despite changing inputs
        op_a = rnd512(); op_b = rnd512(); vlen_sel = 2'd0;
        op_valid = 1'b0;
        @(posedge clk); #2; check_out("R13");
        @(posedge clk); #2; check_out("R13");

        // R1: reset after activity
        do_reset();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule